// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block sits on the host side of a flash memory zone. It runs a complete program or erase job over a simple request/acknowledge bus, and the host needs to raise only one start pulse. For a program job it works through a run of consecutive locations and fetches each data word from a small buffer port by index. For an erase job it targets a single block address. After the data or confirm write it reads status again and again until the device reports ready. It then classifies the status through a fixed chain of checks, clears the status after any failure, and always leaves the zone in array-read mode unless the device has stopped answering.

While it waits for ready, a suspend request makes it suspend the running operation. It confirms the suspension, switches the zone to array reads, reads one host-chosen address and resumes the operation. A wide mode drives both byte lanes with 16-bit bus words. In that mode each command byte is copied to both lanes, and the two lanes' status bits are combined. A poll watchdog ends a job that never becomes ready.

States: `ST_IDLE` (wait for start), `ST_SETUP` (write the setup command), `ST_LOAD` (write the data or confirm), `ST_POLL` (read status), `ST_JUDGE` (classify the status), `ST_CLEAR` (write the clear-status command), `ST_RESTORE` (write the array-read command), `ST_HALT_REQ` (write the suspend command), `ST_HALT_POLL` (read status while suspending), `ST_PEEK_MODE` (write the array-read command before the side read), `ST_PEEK` (side read), `ST_CONTINUE` (write the resume command), `ST_FINISH` (done pulse).

Transitions:
- `ST_IDLE` goes to `ST_SETUP` on start.
- `ST_SETUP` goes to `ST_LOAD`, and `ST_LOAD` goes to `ST_POLL`, each on acknowledge.
- `ST_POLL` goes to `ST_JUDGE` when the status is ready. When it is not ready, it goes to `ST_HALT_REQ` if a suspend is requested, otherwise to `ST_FINISH` if the watchdog has expired, otherwise it stays in `ST_POLL`.
- `ST_JUDGE` goes to `ST_CLEAR` on an error. With no error it goes to `ST_SETUP` for the next program location, or to `ST_RESTORE` when the job is complete.
- `ST_CLEAR` goes to `ST_RESTORE`, and `ST_RESTORE` goes to `ST_FINISH`.
- `ST_HALT_REQ` goes to `ST_HALT_POLL`.
- `ST_HALT_POLL` goes to `ST_PEEK_MODE` when ready with the suspend bit set, to `ST_JUDGE` when ready without it, and to `ST_FINISH` on timeout.
- `ST_PEEK_MODE`, `ST_PEEK` and `ST_CONTINUE` follow one another, and `ST_CONTINUE` returns to `ST_POLL`.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `bus_req_o` are all low.
- R2: A program job with last offset N writes, for each offset i from 0 to N in turn, the command 40h and then buffer word i at address base+i. It then polls status at that address until bit 7 is 1. After offset N it writes FFh at the base address and ends with result code 0 (pass). A bus request holds its address, direction and data until it is acknowledged.
- R3: An erase job writes 20h and then D0h at the base address, polls until ready, writes FFh at the base address and ends with result code 0.
- R4: In wide mode every command byte appears on both byte lanes (for example 4040h), and a program data word is sent with all 16 bits. Ready needs both bit 7 and bit 15. In narrow mode only the low lane carries data and the upper lane is driven to 00h.
- R5: In wide mode an error bit n counts as set when bit n or bit n+8 is 1.
- R6: The supply-error bit 3 is checked first and gives result code 1. For a program job, the program-error bit 4 is checked next and gives result code 2.
- R7: For an erase job with bit 3 clear, bits 4 and 5 both set give result code 4 (sequence error). Bit 5 alone gives result code 3 (erase failure).
- R8: After any failure the block writes 50h, then FFh at the base address, and then ends. A failing program job stops at the failing location.
- R9: A suspend request seen at a status read that returned not-ready causes this sequence: B0h is written, status is polled until ready, and the suspend bit is confirmed (bit 2 for program, bit 6 for erase, both lanes in wide mode). Then FFh is written, the side address is read into `peek_data_o`, D0h is written, and polling resumes.
- R10: If the status after a suspend is ready but the suspend bit is clear, the operation is treated as finished: it is classified at once, with no side read and no resume write.
- R11: A suspend request present only while the block is not polling has no effect on the bus sequence.
- R12: If polling runs for POLL_LIMIT cycles without ready, the job ends with result code 5 and no further bus writes.
- R13: `busy_o` is high from the cycle after start until the end of the job. `done_o` is a one-cycle pulse with `result_o` valid. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| erase_i | input | 1 | 1 = erase job, 0 = program job |
| wide_i | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| base_addr_i | input | AW | First location or block address |
| last_off_i | input | OW | Offset of the last location to program |
| buf_idx_o | output | OW | Index of the buffer word requested |
| buf_data_i | input | 16 | Buffer word at `buf_idx_o` |
| suspend_req_i | input | 1 | Request to suspend for one side read |
| peek_addr_i | input | AW | Address of the side read |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_ack_i | input | 1 | Bus cycle completes in this cycle |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| peek_data_o | output | 16 | Data from the last side read |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| result_o | output | 3 | 0 pass, 1 supply, 2 program, 3 erase, 4 sequence, 5 timeout |

## Verification
The main function is tried with status words that are ready at once, ready after several busy polls, and ready on only one lane. These cases separate the lane-AND ready rule from a single-lane test. Error patterns with two bits set (bits 3 and 4, bits 4 and 5) show whether the checks run in the right order, and an error placed only in the upper lane shows whether the lanes are ORed. Suspend requests are placed at a poll, only during the setup writes, and against a device that finishes instead of suspending, so the honoured, ignored and already-finished paths can each be told apart from the bus write sequence.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_POLL,
        ST_JUDGE,
        ST_CLEAR,
        ST_RESTORE,
        ST_HALT_REQ,
        ST_HALT_POLL,
        ST_PEEK_MODE,
        ST_PEEK,
        ST_CONTINUE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_PASS    = 3'd0,
        RES_SUPPLY  = 3'd1,
        RES_PROG    = 3'd2,
        RES_ERASE   = 3'd3,
        RES_ORDER   = 3'd4,
        RES_TIMEOUT = 3'd5
    } seq_result_t;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_CLEAR       = 8'h50;
    localparam logic [7:0] CMD_ARRAY       = 8'hFF;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

    localparam int BIT_READY  = 7;
    localparam int BIT_EHOLD  = 6;
    localparam int BIT_EFAIL  = 5;
    localparam int BIT_PFAIL  = 4;
    localparam int BIT_SUPPLY = 3;
    localparam int BIT_PHOLD  = 2;

    typedef struct packed {
        logic ready;
        logic supply_err;
        logic prog_err;
        logic erase_err;
        logic prog_held;
        logic erase_held;
    } stat_view_t;

endpackage

// File: rtl/lane_merge.sv
module lane_merge
    import fseq_pkg::*;
(
    input  logic [15:0] raw_i,
    input  logic        wide_i,
    output stat_view_t  view_o
);
    // Flags that must hold on every active lane (ready, held).
    function automatic logic both(input logic [15:0] r, input int b, input logic w);
        return r[b] & (r[b+8] | ~w);
    endfunction

    // Flags that count when any active lane reports them (errors).
    function automatic logic either(input logic [15:0] r, input int b, input logic w);
        return r[b] | (r[b+8] & w);
    endfunction

    always_comb begin
        view_o.ready      = both(raw_i, BIT_READY, wide_i);
        view_o.prog_held  = both(raw_i, BIT_PHOLD, wide_i);
        view_o.erase_held = both(raw_i, BIT_EHOLD, wide_i);
        view_o.supply_err = either(raw_i, BIT_SUPPLY, wide_i);
        view_o.prog_err   = either(raw_i, BIT_PFAIL, wide_i);
        view_o.erase_err  = either(raw_i, BIT_EFAIL, wide_i);
    end
endmodule

// File: rtl/word_format.sv
module word_format #(
    parameter int LANES = 2
) (
    input  logic [7:0]         cmd_i,
    input  logic [8*LANES-1:0] data_i,
    input  logic               use_data_i,
    input  logic               wide_i,
    output logic [8*LANES-1:0] word_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign word_o[7:0] = use_data_i ? data_i[7:0] : cmd_i;
        end else begin : g_up
            assign word_o[8*g +: 8] = !wide_i    ? 8'h00 :
                                      use_data_i ? data_i[8*g +: 8] : cmd_i;
        end
    end
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i) begin
            cnt_q <= '0;
        end else if (cnt_q < LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= LIM);

    assert_expiry_needs_poll_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !expired_o);
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import fseq_pkg::*;
#(
    parameter int AW         = 24,
    parameter int OW         = 8,
    parameter int POLL_LIMIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic          wide_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [OW-1:0] last_off_i,
    output logic [OW-1:0] buf_idx_o,
    input  logic [15:0]   buf_data_i,
    input  logic          suspend_req_i,
    input  logic [AW-1:0] peek_addr_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [15:0]   bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [15:0]   bus_rdata_i,
    output logic [15:0]   peek_data_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [2:0]    result_o
);
    seq_state_t  state_q, state_d;
    seq_result_t result_q, res_d;

    logic          erase_q, wide_q;
    logic [AW-1:0] base_q, peek_addr_q, loc_addr;
    logic [OW-1:0] last_q, idx_q;
    logic [15:0]   stat_q, peek_q, view_src;
    logic          accept, stat_ld, peek_ld, idx_inc;
    logic          poll_phase, expired;
    logic [7:0]    cmd_byte;
    logic          use_data;
    stat_view_t    view;

    assign poll_phase = (state_q == ST_POLL) || (state_q == ST_HALT_POLL);
    assign view_src   = poll_phase ? bus_rdata_i : stat_q;
    assign loc_addr   = base_q + AW'(idx_q);

    lane_merge u_lane_merge (
        .raw_i  (view_src),
        .wide_i (wide_q),
        .view_o (view)
    );

    poll_watchdog #(.LIMIT(POLL_LIMIT)) u_poll_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (poll_phase),
        .expired_o (expired)
    );

    word_format #(.LANES(2)) u_word_format (
        .cmd_i      (cmd_byte),
        .data_i     (buf_data_i),
        .use_data_i (use_data),
        .wide_i     (wide_q),
        .word_o     (bus_wdata_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath strobes
    always_comb begin
        state_d = state_q;
        res_d   = result_q;
        accept  = 1'b0;
        stat_ld = 1'b0;
        peek_ld = 1'b0;
        idx_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    res_d   = RES_PASS;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP:    if (bus_ack_i) state_d = ST_LOAD;
            ST_LOAD:     if (bus_ack_i) state_d = ST_POLL;
            ST_POLL: begin
                if (bus_ack_i) begin
                    if (view.ready) begin
                        stat_ld = 1'b1;
                        state_d = ST_JUDGE;
                    end else if (suspend_req_i) begin
                        state_d = ST_HALT_REQ;
                    end else if (expired) begin
                        res_d   = RES_TIMEOUT;
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_JUDGE: begin
                if (view.supply_err) begin
                    res_d   = RES_SUPPLY;
                    state_d = ST_CLEAR;
                end else if (!erase_q && view.prog_err) begin
                    res_d   = RES_PROG;
                    state_d = ST_CLEAR;
                end else if (erase_q && view.prog_err && view.erase_err) begin
                    res_d   = RES_ORDER;
                    state_d = ST_CLEAR;
                end else if (erase_q && view.erase_err) begin
                    res_d   = RES_ERASE;
                    state_d = ST_CLEAR;
                end else if (!erase_q && (idx_q != last_q)) begin
                    idx_inc = 1'b1;
                    state_d = ST_SETUP;
                end else begin
                    state_d = ST_RESTORE;
                end
            end
            ST_CLEAR:    if (bus_ack_i) state_d = ST_RESTORE;
            ST_RESTORE:  if (bus_ack_i) state_d = ST_FINISH;
            ST_HALT_REQ: if (bus_ack_i) state_d = ST_HALT_POLL;
            ST_HALT_POLL: begin
                if (bus_ack_i) begin
                    if (view.ready) begin
                        if (erase_q ? view.erase_held : view.prog_held) begin
                            state_d = ST_PEEK_MODE;
                        end else begin
                            stat_ld = 1'b1;
                            state_d = ST_JUDGE;
                        end
                    end else if (expired) begin
                        res_d   = RES_TIMEOUT;
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_PEEK_MODE: if (bus_ack_i) state_d = ST_PEEK;
            ST_PEEK: begin
                if (bus_ack_i) begin
                    peek_ld = 1'b1;
                    state_d = ST_CONTINUE;
                end
            end
            ST_CONTINUE: if (bus_ack_i) state_d = ST_POLL;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q    <= RES_PASS;
            erase_q     <= 1'b0;
            wide_q      <= 1'b0;
            base_q      <= '0;
            peek_addr_q <= '0;
            last_q      <= '0;
            idx_q       <= '0;
            stat_q      <= '0;
            peek_q      <= '0;
        end else begin
            result_q <= res_d;
            if (accept) begin
                erase_q     <= erase_i;
                wide_q      <= wide_i;
                base_q      <= base_addr_i;
                peek_addr_q <= peek_addr_i;
                last_q      <= last_off_i;
                idx_q       <= '0;
            end
            if (idx_inc) idx_q  <= idx_q + 1'b1;
            if (stat_ld) stat_q <= bus_rdata_i;
            if (peek_ld) peek_q <= bus_rdata_i;
        end
    end

    // Outputs per state
    always_comb begin
        bus_req_o  = 1'b0;
        bus_we_o   = 1'b0;
        bus_addr_o = loc_addr;
        cmd_byte   = CMD_ARRAY;
        use_data   = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
                cmd_byte  = erase_q ? CMD_ERASE_SETUP : CMD_PROG_SETUP;
            end
            ST_LOAD: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
                cmd_byte  = CMD_CONFIRM;
                use_data  = !erase_q;
            end
            ST_POLL, ST_HALT_POLL: bus_req_o = 1'b1;
            ST_CLEAR: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
                cmd_byte  = CMD_CLEAR;
            end
            ST_RESTORE: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b1;
                bus_addr_o = base_q;
            end
            ST_HALT_REQ: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
                cmd_byte  = CMD_SUSPEND;
            end
            ST_PEEK_MODE: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
            end
            ST_PEEK: begin
                bus_req_o  = 1'b1;
                bus_addr_o = peek_addr_q;
            end
            ST_CONTINUE: begin
                bus_req_o = 1'b1;
                bus_we_o  = 1'b1;
                cmd_byte  = CMD_CONFIRM;
            end
            default: ;
        endcase
    end

    assign buf_idx_o   = idx_q;
    assign peek_data_o = peek_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FINISH);
    assign result_o    = result_q;

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
                                       && $stable(bus_we_o) && $stable(bus_wdata_o)));

    assert_wide_dup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && wide_q && !use_data)
            |-> (bus_wdata_o[15:8] == bus_wdata_o[7:0]));

    assert_clear_after_judge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && $past(state_q) != ST_CLEAR) |-> $past(state_q) == ST_JUDGE);

    assert_halt_from_poll_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT_REQ && $past(state_q) != ST_HALT_REQ)
            |-> ($past(state_q) == ST_POLL && $past(suspend_req_i)));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/test_flash_op_sequencer.sv
`timescale 1ns/1ps
module test_flash_op_sequencer;
    localparam int AW = 24;
    localparam int OW = 8;
    localparam int LIM = 40;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start, erase, wide, sus_req;
    logic [AW-1:0] base_addr, peek_addr, bus_addr;
    logic [OW-1:0] last_off, buf_idx;
    logic [15:0]   buf_data, bus_wdata, bus_rdata, peek_data;
    logic          bus_req, bus_we, bus_ack, busy, done;
    logic [2:0]    result;

    flash_op_sequencer #(.AW(AW), .OW(OW), .POLL_LIMIT(LIM)) i_flash_op_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .erase_i(erase), .wide_i(wide),
        .base_addr_i(base_addr), .last_off_i(last_off), .buf_idx_o(buf_idx),
        .buf_data_i(buf_data), .suspend_req_i(sus_req), .peek_addr_i(peek_addr),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .peek_data_o(peek_data), .busy_o(busy), .done_o(done), .result_o(result)
    );

    assign buf_data = {8'h3C ^ buf_idx, 8'h51 + buf_idx};

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [39:0] expq[$];

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Device model configuration
    int         cfg_busy, cfg_busy_res;
    logic [15:0] cfg_nr, cfg_fin;
    bit         cfg_sus;
    logic [7:0] cfg_susbit, sus_drop;

    // Device model state
    logic       m_ack = 1'b0;
    logic [15:0] m_rdata = '0;
    bit         m_stat = 0, m_arm = 0, m_susp = 0;
    int         m_busy = 0;
    logic [15:0] m_fin = 16'h8080;
    logic [7:0] c;

    assign bus_ack   = m_ack;
    assign bus_rdata = m_rdata;

    // Model plus scoreboard monitor for write cycles
    always @(posedge clk) begin
        if (bus_req && !m_ack) begin
            m_ack <= 1'b1;
            if (!bus_we) begin
                if (m_stat) begin
                    if (m_busy > 0) begin
                        m_rdata <= cfg_nr;
                        m_busy = m_busy - 1;
                    end else if (m_susp) begin
                        m_rdata <= {cfg_susbit | 8'h80, cfg_susbit | 8'h80};
                    end else begin
                        m_rdata <= m_fin;
                    end
                end else begin
                    m_rdata <= 16'hA55A ^ bus_addr[15:0];
                end
            end
        end else begin
            m_ack <= 1'b0;
        end
        if (bus_req && m_ack && bus_we) begin
            if (expq.size() == 0) begin
                chk(0, "R2 unexpected bus write", {bus_addr, bus_wdata}, 40'h0);
            end else begin
                logic [39:0] e;
                e = expq.pop_front();
                chk({bus_addr, bus_wdata} == e, "R2 bus write order", {bus_addr, bus_wdata}, e);
            end
            c = bus_wdata[7:0];
            if (c == sus_drop) sus_req <= 1'b0;
            if (m_arm) begin
                m_arm = 0;
                m_busy = cfg_busy;
                m_stat = 1;
            end else begin
                case (c)
                    8'hFF: m_stat = 0;
                    8'h40, 8'h20: begin m_arm = 1; m_stat = 1; m_fin = cfg_fin; m_susp = 0; end
                    8'hB0: begin m_stat = 1; if (cfg_sus) begin m_susp = 1; m_busy = 1; end end
                    8'hD0: begin m_stat = 1; if (m_susp) begin m_susp = 0; m_busy = cfg_busy_res; end end
                    8'h50: begin m_stat = 1; m_fin = 16'h8080; end
                    default: m_stat = 1;
                endcase
            end
        end
    end

    function automatic logic [15:0] cw(input logic [7:0] cmd, input bit wd);
        return wd ? {cmd, cmd} : {8'h00, cmd};
    endfunction

    function automatic logic [15:0] dw(input int i, input bit wd);
        logic [7:0] lo, hi;
        lo = 8'h51 + 8'(i);
        hi = 8'h3C ^ 8'(i);
        return wd ? {hi, lo} : {8'h00, lo};
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic [15:0] d);
        expq.push_back({a, d});
    endtask

    task automatic model_cfg(input int bz, input logic [15:0] nr, input logic [15:0] fin,
                             input bit sus, input logic [7:0] sbit, input int bres);
        cfg_busy = bz; cfg_nr = nr; cfg_fin = fin;
        cfg_sus = sus; cfg_susbit = sbit; cfg_busy_res = bres;
    endtask

    task automatic go(input bit er, input bit wd, input logic [AW-1:0] base, input logic [OW-1:0] last,
                      input logic [AW-1:0] pk, input logic [2:0] exp_res, input string tag,
                      input bit poke);
        @(negedge clk);
        erase = er; wide = wd; base_addr = base; last_off = last; peek_addr = pk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R13 busy after start"}, 40'(busy), 40'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(result == exp_res, {tag, " result code"}, 40'(result), 40'(exp_res));
        chk(expq.size() == 0, {tag, " all expected writes issued"}, 40'(expq.size()), 40'd0);
        @(negedge clk);
        chk(!busy && !done, {tag, " R13 idle after done"}, 40'({busy, done}), 40'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 0; erase = 0; wide = 0; sus_req = 0; sus_drop = 8'h00;
        base_addr = '0; peek_addr = '0; last_off = '0;
        model_cfg(0, 16'h0000, 16'h0080, 0, 8'h00, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R1 reset idle", 40'({busy, done, bus_req}), 40'd0);

        // R2: narrow program of three locations
        model_cfg(2, 16'h0000, 16'h0080, 0, 8'h00, 0);
        for (int i = 0; i < 3; i++) begin
            push(24'h001000 + i, cw(8'h40, 0));
            push(24'h001000 + i, dw(i, 0));
        end
        push(24'h001000, cw(8'hFF, 0));
        go(0, 0, 24'h001000, 8'd2, 24'h0, 3'd0, "R2 narrow program", 0);

        // R4: wide program, low lane ready before the high lane
        model_cfg(2, 16'h0080, 16'h8080, 0, 8'h00, 0);
        for (int i = 0; i < 2; i++) begin
            push(24'h002000 + i, cw(8'h40, 1));
            push(24'h002000 + i, dw(i, 1));
        end
        push(24'h002000, cw(8'hFF, 1));
        go(0, 1, 24'h002000, 8'd1, 24'h0, 3'd0, "R4 wide program", 0);

        // R6 R8: program error stops at first location
        model_cfg(1, 16'h0000, 16'h0090, 0, 8'h00, 0);
        push(24'h003000, cw(8'h40, 0));
        push(24'h003000, dw(0, 0));
        push(24'h003000, cw(8'h50, 0));
        push(24'h003000, cw(8'hFF, 0));
        go(0, 0, 24'h003000, 8'd2, 24'h0, 3'd2, "R6 R8 program error", 0);

        // R6: supply error outranks program error
        model_cfg(1, 16'h0000, 16'h0098, 0, 8'h00, 0);
        push(24'h003100, cw(8'h40, 0));
        push(24'h003100, dw(0, 0));
        push(24'h003100, cw(8'h50, 0));
        push(24'h003100, cw(8'hFF, 0));
        go(0, 0, 24'h003100, 8'd0, 24'h0, 3'd1, "R6 supply priority", 0);

        // R3 R13: narrow erase, extra start while busy ignored
        model_cfg(3, 16'h0000, 16'h0080, 0, 8'h00, 0);
        push(24'h040000, cw(8'h20, 0));
        push(24'h040000, cw(8'hD0, 0));
        push(24'h040000, cw(8'hFF, 0));
        go(1, 0, 24'h040000, 8'd0, 24'h0, 3'd0, "R3 R13 erase and busy start", 1);

        // R5 R7: wide erase, sequence error only in the high lane
        model_cfg(1, 16'h0000, 16'hB080, 0, 8'h00, 0);
        push(24'h050000, cw(8'h20, 1));
        push(24'h050000, cw(8'hD0, 1));
        push(24'h050000, cw(8'h50, 1));
        push(24'h050000, cw(8'hFF, 1));
        go(1, 1, 24'h050000, 8'd0, 24'h0, 3'd4, "R5 R7 sequence error", 0);

        // R7: erase failure (bit 5 only)
        model_cfg(1, 16'h0000, 16'h00A0, 0, 8'h00, 0);
        push(24'h060000, cw(8'h20, 0));
        push(24'h060000, cw(8'hD0, 0));
        push(24'h060000, cw(8'h50, 0));
        push(24'h060000, cw(8'hFF, 0));
        go(1, 0, 24'h060000, 8'd0, 24'h0, 3'd3, "R7 erase failure", 0);

        // R5: wide program, error only in the high lane
        model_cfg(1, 16'h0000, 16'h9080, 0, 8'h00, 0);
        push(24'h007000, cw(8'h40, 1));
        push(24'h007000, dw(0, 1));
        push(24'h007000, cw(8'h50, 1));
        push(24'h007000, cw(8'hFF, 1));
        go(0, 1, 24'h007000, 8'd3, 24'h0, 3'd2, "R5 high lane error", 0);

        // R9: erase suspend with side read
        model_cfg(2, 16'h0000, 16'h0080, 1, 8'h40, 1);
        sus_drop = 8'hB0; sus_req = 1'b1;
        push(24'h080000, cw(8'h20, 0));
        push(24'h080000, cw(8'hD0, 0));
        push(24'h080000, cw(8'hB0, 0));
        push(24'h080000, cw(8'hFF, 0));
        push(24'h080000, cw(8'hD0, 0));
        push(24'h080000, cw(8'hFF, 0));
        go(1, 0, 24'h080000, 8'd0, 24'h000123, 3'd0, "R9 erase suspend", 0);
        chk(peek_data == (16'hA55A ^ 16'h0123), "R9 side read data", 40'(peek_data), 40'(16'hA55A ^ 16'h0123));

        // R9: wide program suspend
        model_cfg(2, 16'h0000, 16'h8080, 1, 8'h04, 1);
        sus_drop = 8'hB0; sus_req = 1'b1;
        push(24'h009000, cw(8'h40, 1));
        push(24'h009000, dw(0, 1));
        push(24'h009000, cw(8'hB0, 1));
        push(24'h009000, cw(8'hFF, 1));
        push(24'h009000, cw(8'hD0, 1));
        push(24'h009000, cw(8'hFF, 1));
        go(0, 1, 24'h009000, 8'd0, 24'h000456, 3'd0, "R9 wide program suspend", 0);
        chk(peek_data == (16'hA55A ^ 16'h0456), "R9 wide side read", 40'(peek_data), 40'(16'hA55A ^ 16'h0456));

        // R10: device finishes instead of suspending
        model_cfg(2, 16'h0000, 16'h0080, 0, 8'h00, 0);
        sus_drop = 8'hB0; sus_req = 1'b1;
        push(24'h0A0000, cw(8'h20, 0));
        push(24'h0A0000, cw(8'hD0, 0));
        push(24'h0A0000, cw(8'hB0, 0));
        push(24'h0A0000, cw(8'hFF, 0));
        go(1, 0, 24'h0A0000, 8'd0, 24'h000777, 3'd0, "R10 finished at suspend", 0);

        // R11: request only during setup writes
        model_cfg(2, 16'h0000, 16'h0080, 1, 8'h40, 1);
        sus_drop = 8'hD0; sus_req = 1'b1;
        push(24'h0B0000, cw(8'h20, 0));
        push(24'h0B0000, cw(8'hD0, 0));
        push(24'h0B0000, cw(8'hFF, 0));
        go(1, 0, 24'h0B0000, 8'd0, 24'h0, 3'd0, "R11 suspend outside poll", 0);
        sus_drop = 8'h00; sus_req = 1'b0;

        // R12: device never ready
        model_cfg(100000, 16'h0000, 16'h0080, 0, 8'h00, 0);
        push(24'h00C000, cw(8'h40, 0));
        push(24'h00C000, dw(0, 0));
        go(0, 0, 24'h00C000, 8'd1, 24'h0, 3'd5, "R12 poll timeout", 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule